// File: doc/BRIEF.md
# Cleanup Run Detector and Context Strobe Packer

This block sits after pass-membership logic in a bit-plane coder that handles a whole four-sample stripe column in one clock. For each column it decides whether the cleanup pass can code the column as a single run, and if so whether a nonzero bit breaks that run and on which row. It then lists every context-data pair the column produces in this cycle and sets a strobe for each. There can be from zero to ten pairs. The pairs are packed into a ten-slot output that starts at slot 0, in emission order, and each slot carries a type tag and a row number.

Downstream context-formation logic reads the packed slots in order. It uses the kind and row tags to choose which table lookup or bit to feed the arithmetic coder. The run decision and interrupt row are also exported, so the run-length symbol value and the two uniform position bits can be formed directly. The block has one register stage: a column presented with `col_valid` appears on the outputs one clock later.

Top module: `rl_ctx_strobe_gen`

## Requirements
- R1: While reset is asserted, and on any cycle after a clock edge where `col_valid` was low, `out_valid`, `run_mode`, `run_intr` and every bit of `slot_act` are 0.
- R2: A column sampled with `col_valid` high at a rising edge has its results on the outputs right after that edge, with `out_valid` high.
- R3: `run_mode` is 1 exactly when `pass_id` is 2 (cleanup; 0 = significance propagation, 1 = refinement, 3 = idle), all four `pflag` bits are 1, and all `sig` and `nbr_sig` bits are 0.
- R4: `run_intr` is 1 exactly when `run_mode` is 1 and some `data` bit is 1. `intr_pos` is then the lowest-numbered row holding a 1 (row 0 is the top of the column). Otherwise `intr_pos` is 0.
- R5: In run mode without interrupt, only slot 0 is active, and it has kind RUNLEN (kind code 0) and row 0.
- R6: In run mode with interrupt, the slots are, in order: RUNLEN with row 0; two UNIFORM slots (kind code 1) with row `intr_pos`, giving the position MSB first; a SIGN slot (kind code 3) for row `intr_pos`. Then, for each row below it from top to bottom, come a DATA slot (kind code 2) when its `pflag` is 1, and a SIGN slot when its data bit is also 1.
- R7: Outside run mode, rows are visited top to bottom. Each row with `pflag` set gets a DATA slot. That slot is followed by a SIGN slot for the same row when its data bit is 1 and its `sig` bit is 0.
- R8: The active slots always form a contiguous block starting at slot 0. Slot k uses kind bits [2k+1:2k] and row bits [2k+1:2k] (for four rows).
- R9: All ten slots are active only when there is a run interrupt at row 0 and all four data bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_valid | input | 1 | A column is presented this cycle |
| pass_id | input | 2 | Current coding pass: 0 propagation, 1 refinement, 2 cleanup, 3 idle |
| pflag | input | 4 | Per-row membership in the current pass |
| data | input | 4 | Per-row magnitude bit of the current bit plane |
| nbr_sig | input | 4 | Per-row flag: a neighbour outside the column is significant |
| sig | input | 4 | Per-row significance before this column is coded |
| out_valid | output | 1 | Outputs hold a processed column |
| run_mode | output | 1 | Column coded as a cleanup run |
| run_intr | output | 1 | The run is broken by a nonzero bit |
| intr_pos | output | 2 | Row of the first nonzero bit in a broken run |
| slot_act | output | 10 | Strobes of the packed context-data slots |
| slot_kind | output | 20 | Two-bit kind tag per slot |
| slot_row | output | 20 | Two-bit row tag per slot |

## Verification
On every cycle the assertions check several properties: the idle state with no strobes, the one-cycle valid timing, that the strobes form a block starting at slot 0, that an interrupt occurs only inside run mode, and the fixed head of a run (one RUNLEN slot, or RUNLEN, two UNIFORM and a SIGN slot when the run is broken). Only the bench scenarios can show that a column's exact slot sequence matches its flags and data bits. The same holds for the chosen interrupt row, the three run-mode conditions, and whether the ten-slot case is reached. The bench compares these against an independent model over directed and random columns.

// File: rtl/rlcs_pkg.sv
package rlcs_pkg;
  typedef enum logic [1:0] {
    PASS_SIGPROP = 2'd0,
    PASS_REFINE  = 2'd1,
    PASS_CLEANUP = 2'd2,
    PASS_IDLE    = 2'd3
  } pass_e;

  typedef enum logic [1:0] {
    SLOT_RUNLEN  = 2'd0,
    SLOT_UNIFORM = 2'd1,
    SLOT_DATA    = 2'd2,
    SLOT_SIGN    = 2'd3
  } slot_kind_e;
endpackage

// File: rtl/rlcs_run_detect.sv
module rlcs_run_detect #(
  parameter int ROWS  = 4,
  parameter int POS_W = 2
) (
  input  logic [1:0]       pass_id,
  input  logic [ROWS-1:0]  pflag,
  input  logic [ROWS-1:0]  data,
  input  logic [ROWS-1:0]  nbr_sig,
  input  logic [ROWS-1:0]  sig,
  output logic             run_mode,
  output logic             run_intr,
  output logic [POS_W-1:0] intr_pos
);
  import rlcs_pkg::*;

  logic [POS_W-1:0] first_one;

  always_comb begin
    run_mode = (pass_id == PASS_CLEANUP) && (&pflag) && !(|sig) && !(|nbr_sig);
    run_intr = run_mode && (|data);
  end

  // topmost set data bit wins: scan from the bottom so lower indices overwrite
  always_comb begin
    first_one = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (data[r]) first_one = POS_W'(r);
    end
    intr_pos = run_intr ? first_one : '0;
  end
endmodule

// File: rtl/rlcs_slot_request.sv
module rlcs_slot_request #(
  parameter int ROWS  = 4,
  parameter int POS_W = 2,
  parameter int NCAND = 1 + POS_W + 2 * ROWS
) (
  input  logic                        run_mode,
  input  logic                        run_intr,
  input  logic [POS_W-1:0]            intr_pos,
  input  logic [ROWS-1:0]             pflag,
  input  logic [ROWS-1:0]             data,
  input  logic [ROWS-1:0]             sig,
  output logic [NCAND-1:0]            cand_act,
  output logic [NCAND-1:0][1:0]       cand_kind,
  output logic [NCAND-1:0][POS_W-1:0] cand_row
);
  import rlcs_pkg::*;

  localparam int ROW_BASE = 1 + POS_W;

  // run-length symbol occupies candidate 0
  assign cand_act[0]  = run_mode;
  assign cand_kind[0] = SLOT_RUNLEN;
  assign cand_row[0]  = '0;

  // uniform position bits, MSB first
  for (genvar u = 0; u < POS_W; u++) begin : g_uni
    assign cand_act[1+u]  = run_intr;
    assign cand_kind[1+u] = SLOT_UNIFORM;
    assign cand_row[1+u]  = intr_pos;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic below_hit;
    logic at_hit;
    logic data_on;
    logic sign_on;

    always_comb begin
      below_hit = run_intr && (POS_W'(r) > intr_pos);
      at_hit    = run_intr && (POS_W'(r) == intr_pos);
      if (run_mode) begin
        data_on = below_hit && pflag[r];
        sign_on = at_hit || (below_hit && pflag[r] && data[r] && !sig[r]);
      end else begin
        data_on = pflag[r];
        sign_on = pflag[r] && data[r] && !sig[r];
      end
    end

    assign cand_act[ROW_BASE+2*r]    = data_on;
    assign cand_kind[ROW_BASE+2*r]   = SLOT_DATA;
    assign cand_row[ROW_BASE+2*r]    = POS_W'(r);
    assign cand_act[ROW_BASE+2*r+1]  = sign_on;
    assign cand_kind[ROW_BASE+2*r+1] = SLOT_SIGN;
    assign cand_row[ROW_BASE+2*r+1]  = POS_W'(r);
  end
endmodule

// File: rtl/rlcs_slot_packer.sv
module rlcs_slot_packer #(
  parameter int POS_W = 2,
  parameter int NCAND = 11,
  parameter int NSLOT = 10
) (
  input  logic [NCAND-1:0]            cand_act,
  input  logic [NCAND-1:0][1:0]       cand_kind,
  input  logic [NCAND-1:0][POS_W-1:0] cand_row,
  output logic [NSLOT-1:0]            slot_act,
  output logic [NSLOT-1:0][1:0]       slot_kind,
  output logic [NSLOT-1:0][POS_W-1:0] slot_row
);
  localparam int IDX_W = $clog2(NCAND + 1);

  always_comb begin
    logic [IDX_W-1:0] fill;
    fill      = '0;
    slot_act  = '0;
    slot_kind = '0;
    slot_row  = '0;
    for (int c = 0; c < NCAND; c++) begin
      if (cand_act[c]) begin
        if (int'(fill) < NSLOT) begin
          slot_act[fill]  = 1'b1;
          slot_kind[fill] = cand_kind[c];
          slot_row[fill]  = cand_row[c];
        end
        fill = fill + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rl_ctx_strobe_gen.sv
module rl_ctx_strobe_gen #(
  parameter int ROWS  = 4,
  parameter int POS_W = $clog2(ROWS),
  parameter int NSLOT = 2 * ROWS + POS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     col_valid,
  input  logic [1:0]               pass_id,
  input  logic [ROWS-1:0]          pflag,
  input  logic [ROWS-1:0]          data,
  input  logic [ROWS-1:0]          nbr_sig,
  input  logic [ROWS-1:0]          sig,
  output logic                     out_valid,
  output logic                     run_mode,
  output logic                     run_intr,
  output logic [POS_W-1:0]         intr_pos,
  output logic [NSLOT-1:0]         slot_act,
  output logic [2*NSLOT-1:0]       slot_kind,
  output logic [POS_W*NSLOT-1:0]   slot_row
);
  localparam int NCAND = 1 + POS_W + 2 * ROWS;

  logic                        rm_c, ri_c;
  logic [POS_W-1:0]            pos_c;
  logic [NCAND-1:0]            cand_act;
  logic [NCAND-1:0][1:0]       cand_kind;
  logic [NCAND-1:0][POS_W-1:0] cand_row;
  logic [NSLOT-1:0]            pk_act;
  logic [NSLOT-1:0][1:0]       pk_kind;
  logic [NSLOT-1:0][POS_W-1:0] pk_row;

  rlcs_run_detect #(.ROWS(ROWS), .POS_W(POS_W)) detect_i (
    .pass_id (pass_id), .pflag(pflag), .data(data), .nbr_sig(nbr_sig), .sig(sig),
    .run_mode(rm_c), .run_intr(ri_c), .intr_pos(pos_c)
  );

  rlcs_slot_request #(.ROWS(ROWS), .POS_W(POS_W), .NCAND(NCAND)) request_i (
    .run_mode(rm_c), .run_intr(ri_c), .intr_pos(pos_c),
    .pflag(pflag), .data(data), .sig(sig),
    .cand_act(cand_act), .cand_kind(cand_kind), .cand_row(cand_row)
  );

  rlcs_slot_packer #(.POS_W(POS_W), .NCAND(NCAND), .NSLOT(NSLOT)) packer_i (
    .cand_act(cand_act), .cand_kind(cand_kind), .cand_row(cand_row),
    .slot_act(pk_act), .slot_kind(pk_kind), .slot_row(pk_row)
  );

  // next state: flags and strobes cleared on idle cycles, tags held
  logic                   valid_d, rm_d, ri_d;
  logic [NSLOT-1:0]       act_d;
  logic [POS_W-1:0]       pos_d;
  logic [2*NSLOT-1:0]     kind_d;
  logic [POS_W*NSLOT-1:0] row_d;

  always_comb begin
    valid_d = col_valid;
    rm_d    = col_valid && rm_c;
    ri_d    = col_valid && ri_c;
    act_d   = col_valid ? pk_act : '0;
    pos_d   = intr_pos;
    kind_d  = slot_kind;
    row_d   = slot_row;
    if (col_valid) begin
      pos_d  = pos_c;
      kind_d = pk_kind;
      row_d  = pk_row;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      run_mode  <= 1'b0;
      run_intr  <= 1'b0;
      intr_pos  <= '0;
      slot_act  <= '0;
      slot_kind <= '0;
      slot_row  <= '0;
    end else begin
      out_valid <= valid_d;
      run_mode  <= rm_d;
      run_intr  <= ri_d;
      intr_pos  <= pos_d;
      slot_act  <= act_d;
      slot_kind <= kind_d;
      slot_row  <= row_d;
    end
  end
endmodule

// File: rtl/rlcs_chk.sv
module rlcs_chk #(
  parameter int ROWS  = 4,
  parameter int POS_W = 2,
  parameter int NSLOT = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               col_valid,
  input logic               out_valid,
  input logic               run_mode,
  input logic               run_intr,
  input logic [POS_W-1:0]   intr_pos,
  input logic [NSLOT-1:0]   slot_act,
  input logic [2*NSLOT-1:0] slot_kind
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!run_mode && !run_intr && slot_act == '0));

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid |=> out_valid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |=> !out_valid);

  // R4
  intr_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_intr |-> run_mode);

  // R5
  plain_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_mode && !run_intr) |-> (slot_act == NSLOT'(1) && slot_kind[1:0] == 2'd0));

  // R6
  broken_run_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_intr |-> ((&slot_act[POS_W+1:0]) && slot_kind[1:0] == 2'd0 &&
                  slot_kind[2*POS_W+3:2*POS_W+2] == 2'd3));

  // R8
  packed_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_act & (slot_act + 1'b1)) == '0);

  // R9
  full_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(slot_act) == NSLOT) |-> (run_intr && intr_pos == '0));
endmodule

bind rl_ctx_strobe_gen rlcs_chk #(.ROWS(ROWS), .POS_W(POS_W), .NSLOT(NSLOT)) chk_i (
  .clk(clk), .rst_n(rst_n), .col_valid(col_valid), .out_valid(out_valid),
  .run_mode(run_mode), .run_intr(run_intr), .intr_pos(intr_pos),
  .slot_act(slot_act), .slot_kind(slot_kind)
);

// File: tb/rl_ctx_strobe_gen_tb_top.sv
module rl_ctx_strobe_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSLOT = 10;

  logic clk, rst_n, col_valid;
  logic [1:0] pass_id;
  logic [3:0] pflag, data, nbr_sig, sig;
  logic out_valid, run_mode, run_intr;
  logic [1:0] intr_pos;
  logic [NSLOT-1:0] slot_act;
  logic [2*NSLOT-1:0] slot_kind, slot_row;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rl_ctx_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .col_valid(col_valid), .pass_id(pass_id),
    .pflag(pflag), .data(data), .nbr_sig(nbr_sig), .sig(sig),
    .out_valid(out_valid), .run_mode(run_mode), .run_intr(run_intr),
    .intr_pos(intr_pos), .slot_act(slot_act), .slot_kind(slot_kind), .slot_row(slot_row)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // expected values from the requirements
  logic exp_rm, exp_ri;
  logic [1:0] exp_pos;
  logic [NSLOT-1:0] exp_act;
  logic [2*NSLOT-1:0] exp_kind, exp_row;
  int exp_n;

  task automatic push(input logic [1:0] k, input logic [1:0] r);
    if (exp_n < NSLOT) begin
      exp_act[exp_n] = 1'b1;
      exp_kind[2*exp_n +: 2] = k;
      exp_row[2*exp_n +: 2] = r;
    end
    exp_n++;
  endtask

  task automatic model();
    exp_act = '0; exp_kind = '0; exp_row = '0; exp_n = 0;
    exp_rm = (pass_id == 2'd2) && pflag == 4'hF && sig == 4'h0 && nbr_sig == 4'h0;
    exp_ri = exp_rm && data != 4'h0;
    exp_pos = 2'd0;
    if (exp_ri) begin
      for (int r = 3; r >= 0; r--) if (data[r]) exp_pos = 2'(r);
    end
    if (exp_rm) begin
      push(2'd0, 2'd0);
      if (exp_ri) begin
        push(2'd1, exp_pos); push(2'd1, exp_pos); push(2'd3, exp_pos);
        for (int r = 0; r < 4; r++) begin
          if (r > int'(exp_pos) && pflag[r]) begin
            push(2'd2, 2'(r));
            if (data[r] && !sig[r]) push(2'd3, 2'(r));
          end
        end
      end
    end else begin
      for (int r = 0; r < 4; r++) begin
        if (pflag[r]) begin
          push(2'd2, 2'(r));
          if (data[r] && !sig[r]) push(2'd3, 2'(r));
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [2*NSLOT-1:0] keep_active(input logic [2*NSLOT-1:0] v,
                                                     input logic [NSLOT-1:0] m);
    logic [2*NSLOT-1:0] o;
    for (int s = 0; s < NSLOT; s++) o[2*s +: 2] = m[s] ? v[2*s +: 2] : 2'b00;
    return o;
  endfunction

  // called at a negedge: drive, wait one cycle, compare
  task automatic apply(input logic [1:0] p, input logic [3:0] pf, input logic [3:0] d,
                       input logic [3:0] nb, input logic [3:0] sg);
    string slot_req;
    col_valid = 1'b1; pass_id = p; pflag = pf; data = d; nbr_sig = nb; sig = sg;
    model();
    @(negedge clk);
    slot_req = exp_rm ? (exp_ri ? "R6" : "R5") : "R7";
    chk("R2 out_valid", 32'(out_valid), 32'd1);
    chk("R3 run_mode", 32'(run_mode), 32'(exp_rm));
    chk("R4 run_intr/intr_pos", {29'd0, run_intr, intr_pos}, {29'd0, exp_ri, exp_pos});
    chk({slot_req, " R8 slot_act"}, 32'(slot_act), 32'(exp_act));
    chk({slot_req, " slot_kind"}, 32'(keep_active(slot_kind, slot_act)), 32'(exp_kind));
    chk({slot_req, " slot_row"}, 32'(keep_active(slot_row, slot_act)), 32'(exp_row));
    if (slot_act == '1) chk("R9 full only on row-0 break with all ones",
                            {30'd0, run_intr && intr_pos == 2'd0, data == 4'hF}, 32'd3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [1:0] p;
    logic [3:0] pf, d, nb, sg;
    void'($urandom(32'd4242));
    rst_n = 1'b0; col_valid = 1'b0; pass_id = 2'd0;
    pflag = '0; data = '0; nbr_sig = '0; sig = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'd0, out_valid, run_mode, run_intr, |slot_act}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {29'd0, out_valid, run_mode, |slot_act}, 32'd0);

    // directed corners
    apply(2'd2, 4'hF, 4'h0, 4'h0, 4'h0); // R5 plain run
    apply(2'd2, 4'hF, 4'hF, 4'h0, 4'h0); // R9 ten slots
    apply(2'd2, 4'hF, 4'h8, 4'h0, 4'h0); // R6 break at last row
    apply(2'd2, 4'hF, 4'hA, 4'h0, 4'h0); // R6 break at row 1
    apply(2'd2, 4'hF, 4'h0, 4'h4, 4'h0); // R3 neighbour kills run
    apply(2'd2, 4'hE, 4'h3, 4'h0, 4'h0); // R3 coded row kills run
    apply(2'd2, 4'hF, 4'h1, 4'h0, 4'h0); // R4 break at row 0
    apply(2'd0, 4'hF, 4'h5, 4'h0, 4'h0); // R10-like: propagation pass never runs
    apply(2'd1, 4'h6, 4'h6, 4'h0, 4'h6); // R7 refinement, no signs
    apply(2'd3, 4'h0, 4'hF, 4'h0, 4'h0); // R7 no members

    // idle cycle between columns
    col_valid = 1'b0;
    @(negedge clk);
    chk("R1 idle cycle", {29'd0, out_valid, run_intr, |slot_act}, 32'd0);

    for (int i = 0; i < 600; i++) begin
      p  = 2'($urandom_range(0, 3));
      pf = 4'($urandom);
      d  = 4'($urandom);
      nb = 4'($urandom);
      sg = 4'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        p = 2'd2; pf = 4'hF; sg = 4'h0;
        nb = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'h0;
      end
      apply(p, pf, d, nb, sg);
      if ($urandom_range(0, 15) == 0) begin
        col_valid = 1'b0;
        @(negedge clk);
        chk("R1 idle in stream", {30'd0, out_valid, |slot_act}, 32'd0);
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule